// File: doc/BRIEF.md
# TMDS Link Test Pattern Generator

This block produces one 10-bit TMDS character per clock for a transmitter data lane. A static source selector picks what the lane carries: all zeros, the normally encoded link data passed straight through, a pseudo-random bit sequence, or a rotating pattern built from eight programmed 10-bit words. The chosen character is registered once before it leaves the block, so every source reaches the output with the same one-cycle latency.

The pseudo-random engine is a Fibonacci LFSR with four selectable polynomials. It can emit 1, 8 or 10 fresh bits per character, or stay idle. The rotating-word generator holds each word for a programmable number of clocks before moving to the next. Beside the data lane, a 40-bit clock pattern register can be loaded and rotated by one character per clock. Its low 10 bits form a separate clock-lane character, for links whose clock runs at a quarter of the character rate. Serialisation happens downstream.

Top module: `tmds_tpg`

## Requirements
- R1: While `rst` is high at a clock edge, `tmds_o` and `clk_char_o` become zero, both generators return to their start state, and the LFSR is loaded with all ones.
- R2: `src_sel` is decoded one-hot: 3'b000 gives zeros, 3'b001 gives link data, 3'b010 gives the LFSR source, and 3'b100 gives the rotating-word source. Every other code gives zeros.
- R3: With `src_sel` = 3'b001, `tmds_o` equals the `tmds_i` value that was present at the previous clock edge.
- R4: `lfsr_poly` selects the feedback taps, and the new bit is the XOR of the two taps: 0 uses x^11+x^9+1, 1 uses x^15+x^14+1, 2 uses x^7+x^6+1, and 3 uses x^31+x^28+1. The shift register holds only as many bits as the polynomial's degree.
- R5: `lfsr_width` sets how many bits the LFSR adds to each character, always filling from character bit 0 with the earliest bit. 0 means idle: zero output and no advance. 1 gives 8 bits with bits 9:8 at zero. 2 gives 1 bit with bits 9:1 at zero. 3 gives all 10 bits.
- R6: While `lfsr_en` is low, the LFSR source reads as zero and the register is reloaded with all ones. The first character after enabling is therefore generated from the all-ones seed.
- R7: `shift_words` holds word k in bits [10k+9:10k]. The rotating source starts at word 0, steps upward, and wraps from word 7 back to word 0.
- R8: A `shift_hold` value of H keeps each word on the output for H+1 consecutive characters.
- R9: While `shift_en` is low, the rotating source reads as zero and restarts at word 0 with a fresh hold count.
- R10: When `clkpat_load` is high, the 40-bit clock register takes `clkpat_data`. Otherwise, when `clkpat_shift` is high, the register rotates right by 10 bits. `clk_char_o` always shows the register's bits 9:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 3 | One-hot output source select |
| lfsr_en | input | 1 | LFSR engine enable |
| lfsr_poly | input | 2 | LFSR polynomial select |
| lfsr_width | input | 2 | LFSR bits per character select |
| shift_en | input | 1 | Rotating-word generator enable |
| shift_hold | input | 3 | Word hold count minus one |
| shift_words | input | 80 | Eight 10-bit words, word 0 in the LSBs |
| clkpat_load | input | 1 | Load the clock pattern register |
| clkpat_shift | input | 1 | Rotate the clock pattern by one character |
| clkpat_data | input | 40 | Clock pattern load value |
| tmds_i | input | 10 | Normally encoded link character |
| tmds_o | output | 10 | Registered output character |
| clk_char_o | output | 10 | Current clock-lane character |

## Verification
On every cycle, the assertions check the output-side rules:
- unlisted select codes give zeros;
- pass-through has a one-cycle delay;
- the unused upper bits stay zero for the 8-bit and 1-bit widths, and the idle width gives zero;
- the LFSR never locks up in the all-zero state;
- the clock character follows a rotation.

The exact bit sequence of each polynomial, the re-seeding after a disable, the word order with its hold counts and wrap, and the load priority of the clock register need a step-by-step reference model. Only the bench scenarios can show these, using directed cases for every polynomial and width and randomised control changes.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    localparam int CHAR_W   = 10;
    localparam int N_WORDS  = 8;
    localparam int HOLD_W   = 3;
    localparam int LFSR_W   = 31;
    localparam int CLKPAT_W = 40;

    typedef enum logic [2:0] {
        SRC_ZERO  = 3'b000,
        SRC_LINK  = 3'b001,
        SRC_LFSR  = 3'b010,
        SRC_SHIFT = 3'b100
    } src_e;

    typedef enum logic [1:0] {
        POLY_11 = 2'd0,
        POLY_15 = 2'd1,
        POLY_7  = 2'd2,
        POLY_31 = 2'd3
    } poly_e;

    typedef enum logic [1:0] {
        WID_IDLE = 2'd0,
        WID_8    = 2'd1,
        WID_1    = 2'd2,
        WID_10   = 2'd3
    } width_e;

    typedef struct packed {
        logic [LFSR_W-1:0] state;
        logic [CHAR_W-1:0] bits;
    } lfsr_res_t;

    function automatic int poly_deg(poly_e p);
        case (p)
            POLY_11: return 11;
            POLY_15: return 15;
            POLY_7:  return 7;
            default: return 31;
        endcase
    endfunction

    function automatic int poly_tap(poly_e p);
        case (p)
            POLY_11: return 9;
            POLY_15: return 14;
            POLY_7:  return 6;
            default: return 28;
        endcase
    endfunction

    function automatic logic [LFSR_W-1:0] poly_mask(poly_e p);
        case (p)
            POLY_11: return 31'h0000_07FF;
            POLY_15: return 31'h0000_7FFF;
            POLY_7:  return 31'h0000_007F;
            default: return 31'h7FFF_FFFF;
        endcase
    endfunction

    function automatic int width_bits(width_e w);
        case (w)
            WID_8:   return 8;
            WID_1:   return 1;
            WID_10:  return 10;
            default: return 0;
        endcase
    endfunction

    // Advance the register n steps; bit i of the result is the i-th new bit.
    function automatic lfsr_res_t lfsr_run(logic [LFSR_W-1:0] s, poly_e p, int n);
        lfsr_res_t r;
        logic      fb;
        int        hi;
        int        lo;
        hi      = poly_deg(p);
        lo      = poly_tap(p);
        r.state = s;
        r.bits  = '0;
        for (int i = 0; i < CHAR_W; i++) begin
            if (i < n) begin
                fb        = r.state[hi-1] ^ r.state[lo-1];
                r.state   = {r.state[LFSR_W-2:0], fb} & poly_mask(p);
                r.bits[i] = fb;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/tpg_lfsr.sv
module tpg_lfsr
    import tpg_pkg::*;
#(
    parameter int W  = CHAR_W,
    parameter int SW = LFSR_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic [1:0]   poly,
    input  logic [1:0]   width,
    output logic [W-1:0] char_o
);
    localparam logic [SW-1:0] SEED = '1;

    logic [SW-1:0] state_q;
    lfsr_res_t     res;

    always_comb begin
        res = lfsr_run(state_q, poly_e'(poly), width_bits(width_e'(width)));
    end

    assign char_o = en ? res.bits : '0;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state_q <= SEED;
        end else begin
            state_q <= res.state;
        end
    end

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (rst)
        en |-> (state_q & poly_mask(poly_e'(poly))) != '0) else $error("lfsr lockup"); // R4

endmodule

// File: rtl/tpg_shift.sv
module tpg_shift
    import tpg_pkg::*;
#(
    parameter int W  = CHAR_W,
    parameter int NW = N_WORDS,
    parameter int HW = HOLD_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            en,
    input  logic [HW-1:0]   hold,
    input  logic [NW*W-1:0] words,
    output logic [W-1:0]    char_o
);
    localparam int IDX_W = (NW > 1) ? $clog2(NW) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NW - 1);

    logic [W-1:0]     word_a [NW];
    logic [IDX_W-1:0] idx_q;
    logic [HW-1:0]    cnt_q;

    for (genvar g = 0; g < NW; g++) begin : g_word
        assign word_a[g] = words[g*W +: W];
    end

    assign char_o = en ? word_a[idx_q] : '0;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            idx_q <= '0;
            cnt_q <= '0;
        end else if (cnt_q >= hold) begin
            cnt_q <= '0;
            idx_q <= (idx_q == LAST) ? '0 : idx_q + 1'b1;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (rst)
        en && $past(en) && $past(cnt_q) < $past(hold) |-> $stable(idx_q)) else $error("word moved early"); // R8

endmodule

// File: rtl/tpg_clkpat.sv
module tpg_clkpat
    import tpg_pkg::*;
#(
    parameter int W  = CHAR_W,
    parameter int PW = CLKPAT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          shift,
    input  logic [PW-1:0] data,
    output logic [W-1:0]  char_o
);
    logic [PW-1:0] pat_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pat_q <= '0;
        end else if (load) begin
            pat_q <= data;
        end else if (shift) begin
            pat_q <= {pat_q[W-1:0], pat_q[PW-1:W]};
        end
    end

    assign char_o = pat_q[W-1:0];

    AST_CLK_ROT: assert property (@(posedge clk) disable iff (rst)
        !load && shift |=> char_o == $past(pat_q[2*W-1:W])) else $error("clock rotate"); // R10

endmodule

// File: rtl/tmds_tpg.sv
module tmds_tpg
    import tpg_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic [2:0]               src_sel,
    input  logic                     lfsr_en,
    input  logic [1:0]               lfsr_poly,
    input  logic [1:0]               lfsr_width,
    input  logic                     shift_en,
    input  logic [HOLD_W-1:0]        shift_hold,
    input  logic [N_WORDS*CHAR_W-1:0] shift_words,
    input  logic                     clkpat_load,
    input  logic                     clkpat_shift,
    input  logic [CLKPAT_W-1:0]      clkpat_data,
    input  logic [CHAR_W-1:0]        tmds_i,
    output logic [CHAR_W-1:0]        tmds_o,
    output logic [CHAR_W-1:0]        clk_char_o
);
    logic [CHAR_W-1:0] lfsr_char;
    logic [CHAR_W-1:0] shift_char;
    logic [CHAR_W-1:0] mux_char;

    tpg_lfsr #(.W(CHAR_W), .SW(LFSR_W)) u_lfsr (
        .clk    (clk),
        .rst    (rst),
        .en     (lfsr_en),
        .poly   (lfsr_poly),
        .width  (lfsr_width),
        .char_o (lfsr_char)
    );

    tpg_shift #(.W(CHAR_W), .NW(N_WORDS), .HW(HOLD_W)) u_shift (
        .clk    (clk),
        .rst    (rst),
        .en     (shift_en),
        .hold   (shift_hold),
        .words  (shift_words),
        .char_o (shift_char)
    );

    tpg_clkpat #(.W(CHAR_W), .PW(CLKPAT_W)) u_clkpat (
        .clk    (clk),
        .rst    (rst),
        .load   (clkpat_load),
        .shift  (clkpat_shift),
        .data   (clkpat_data),
        .char_o (clk_char_o)
    );

    always_comb begin
        case (src_sel)
            SRC_LINK:  mux_char = tmds_i;
            SRC_LFSR:  mux_char = lfsr_char;
            SRC_SHIFT: mux_char = shift_char;
            default:   mux_char = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tmds_o <= '0;
        end else begin
            tmds_o <= mux_char;
        end
    end

    AST_UNLISTED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !(src_sel inside {3'b001, 3'b010, 3'b100}) |=> tmds_o == '0) else $error("unlisted sel"); // R2
    AST_PASS_DELAY: assert property (@(posedge clk) disable iff (rst)
        src_sel == 3'b001 |=> tmds_o == $past(tmds_i)) else $error("pass delay"); // R3
    AST_NARROW_8: assert property (@(posedge clk) disable iff (rst)
        src_sel == 3'b010 && lfsr_width == 2'd1 |=> tmds_o[9:8] == 2'b00) else $error("width 8"); // R5
    AST_NARROW_1: assert property (@(posedge clk) disable iff (rst)
        src_sel == 3'b010 && lfsr_width == 2'd2 |=> tmds_o[9:1] == '0) else $error("width 1"); // R5
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
        src_sel == 3'b010 && (lfsr_width == 2'd0 || !lfsr_en) |=> tmds_o == '0) else $error("idle"); // R6

endmodule

// File: tb/tmds_tpg_tb.sv
module tmds_tpg_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  src_sel = '0;
    logic        lfsr_en = 1'b0;
    logic [1:0]  lfsr_poly = '0;
    logic [1:0]  lfsr_width = '0;
    logic        shift_en = 1'b0;
    logic [2:0]  shift_hold = '0;
    logic [79:0] shift_words = '0;
    logic        clkpat_load = 1'b0;
    logic        clkpat_shift = 1'b0;
    logic [39:0] clkpat_data = '0;
    logic [9:0]  tmds_i = '0;
    logic [9:0]  tmds_o;
    logic [9:0]  clk_char_o;

    int n_chk = 0;
    int n_fail = 0;

    logic [30:0] m_lfsr = '1;
    logic [2:0]  m_idx = '0;
    logic [2:0]  m_cnt = '0;
    logic [39:0] m_clk = '0;

    always #10 clk = ~clk;

    tmds_tpg u_dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .lfsr_en(lfsr_en),
        .lfsr_poly(lfsr_poly), .lfsr_width(lfsr_width), .shift_en(shift_en),
        .shift_hold(shift_hold), .shift_words(shift_words),
        .clkpat_load(clkpat_load), .clkpat_shift(clkpat_shift),
        .clkpat_data(clkpat_data), .tmds_i(tmds_i), .tmds_o(tmds_o),
        .clk_char_o(clk_char_o)
    );

    function automatic void ref_lfsr(input logic [30:0] s_in, input logic [1:0] mode,
                                     input logic [1:0] w, output logic [9:0] bits,
                                     output logic [30:0] s_out);
        int hi; int lo; int n; logic fb; logic [31:0] mk; logic [30:0] s;
        case (mode)
            2'd0: begin hi = 11; lo = 9; end
            2'd1: begin hi = 15; lo = 14; end
            2'd2: begin hi = 7;  lo = 6; end
            default: begin hi = 31; lo = 28; end
        endcase
        n  = (w == 2'd1) ? 8 : (w == 2'd2) ? 1 : (w == 2'd3) ? 10 : 0;
        mk = (32'd1 << hi) - 32'd1;
        s = s_in; bits = '0;
        for (int i = 0; i < n; i++) begin
            fb = s[hi-1] ^ s[lo-1];
            s = {s[29:0], fb} & mk[30:0];
            bits[i] = fb;
        end
        s_out = s;
    endfunction

    task automatic check(input string req, input logic [9:0] act, input logic [9:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Inputs are already set at a falling edge; model one rising edge and compare.
    task automatic tick(input string req);
        logic [9:0] exp_o; logic [9:0] bits; logic [30:0] nxt;
        ref_lfsr(m_lfsr, lfsr_poly, lfsr_width, bits, nxt);
        case (src_sel)
            3'b001: exp_o = tmds_i;
            3'b010: exp_o = lfsr_en ? bits : '0;
            3'b100: exp_o = shift_en ? shift_words[m_idx*10 +: 10] : '0;
            default: exp_o = '0;
        endcase
        m_lfsr = lfsr_en ? nxt : '1;
        if (!shift_en) begin m_idx = '0; m_cnt = '0; end
        else if (m_cnt >= shift_hold) begin m_cnt = '0; m_idx = m_idx + 3'd1; end
        else m_cnt = m_cnt + 3'd1;
        if (clkpat_load) m_clk = clkpat_data;
        else if (clkpat_shift) m_clk = {m_clk[9:0], m_clk[39:10]};
        @(posedge clk); #1;
        check(req, tmds_o, exp_o);
        check("R10", clk_char_o, m_clk[9:0]);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tmds_i = 10'h3A5;
        repeat (3) @(posedge clk);
        #1;
        check("R1", tmds_o, '0);
        check("R1", clk_char_o, '0);
        @(negedge clk);
        rst = 1'b0;

        // R2 R3: every select code with random link data
        for (int s = 0; s < 8; s++) begin
            for (int k = 0; k < 3; k++) begin
                src_sel = 3'(s); tmds_i = 10'($urandom);
                tick(s == 1 ? "R3" : "R2");
            end
        end

        // R4 R5 R6: each polynomial and width from the seed
        src_sel = 3'b010;
        for (int p = 0; p < 4; p++) begin
            for (int w = 0; w < 4; w++) begin
                lfsr_en = 1'b0; lfsr_poly = 2'(p); lfsr_width = 2'(w);
                tick("R6");
                lfsr_en = 1'b1;
                for (int k = 0; k < 40; k++) tick(w == 3 ? "R4" : "R5");
            end
        end
        lfsr_en = 1'b0;
        tick("R6");

        // R7 R8 R9: rotating words with several hold counts
        src_sel = 3'b100;
        for (int h = 0; h < 8; h++) begin
            for (int i = 0; i < 8; i++) shift_words[i*10 +: 10] = 10'($urandom);
            shift_en = 1'b0; shift_hold = 3'(h);
            tick("R9");
            shift_en = 1'b1;
            for (int k = 0; k < 8 * (h + 1) + 5; k++) tick(h == 0 ? "R7" : "R8");
        end
        shift_en = 1'b0;
        tick("R9");

        // R10: load takes priority over shift, then rotate and hold
        clkpat_data = {$urandom, $urandom} % (64'd1 << 40);
        clkpat_load = 1'b1; clkpat_shift = 1'b1;
        tick("R10");
        clkpat_load = 1'b0;
        for (int k = 0; k < 6; k++) tick("R10");
        clkpat_shift = 1'b0;
        tick("R10");

        // Random mix; polynomial changes only while the engine is off
        for (int k = 0; k < 3000; k++) begin
            src_sel = ($urandom % 4 == 0) ? 3'($urandom) : 3'(1 << ($urandom % 3));
            tmds_i = 10'($urandom);
            lfsr_width = 2'($urandom);
            if ($urandom % 16 == 0) begin lfsr_en = 1'b0; lfsr_poly = 2'($urandom); end
            else if ($urandom % 8 == 0) lfsr_en = 1'b1;
            if ($urandom % 20 == 0) shift_en = ~shift_en;
            if ($urandom % 30 == 0) shift_hold = 3'($urandom);
            if ($urandom % 50 == 0) shift_words[($urandom % 8)*10 +: 10] = 10'($urandom);
            clkpat_load = ($urandom % 25 == 0);
            clkpat_shift = 1'($urandom);
            clkpat_data = {8'($urandom), $urandom};
            tick("R2");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule